// File: doc/BRIEF.md
# Byte-Count FIFO Register Port

This block puts a small register interface in front of a byte-wide data FIFO that links a bus host to a serial engine. The host reaches the FIFO through a 32-bit data register. Each access moves between one and four bytes, as set in a byte-count register. A write to the data register stores bytes taken from the low end of the word. A read from it removes bytes and packs them into the returned word. On the other side, the engine pushes or pops one byte per cycle.

A status register gives the fill level in bytes. Before writing, the host works out the free space as the depth minus that level, so it can throttle its own traffic. A control register empties the buffer and clears a sticky error flag. That flag records any attempt to push more bytes than fit, or to pop more bytes than are held. In either case only the bytes that can actually move are moved. Byte order is little-endian throughout: the first byte pushed or popped sits in bits [7:0] of the word.

Top module: `bytefifo_port`

## Requirements
- R1: After reset the level is 0, the byte count is 4, the error flag is 0, engEmpty is 1, engFull is 0 and hostRdData is 0.
- R2: A host write to the data register (hostAddr 0) stores the current count of bytes from hostWdata, starting at bits [7:0]. The byte in bits [7:0] is the first one that leaves the FIFO.
- R3: A host read of the data register removes the current count of bytes. The oldest byte goes to bits [7:0] and each later byte to the next byte lane above it. Lanes above the count read as zero. The result appears on hostRdData one clock after the access.
- R4: A write to the count register (hostAddr 1) takes bits [2:0] when they hold 1 to 4. Any other value leaves the count unchanged. A read of hostAddr 1 returns the count in bits [2:0].
- R5: A read of the status register (hostAddr 2) returns the level in bytes in bits [7:0] and the error flag in bit 8. The FIFO depth is 64 bytes.
- R6: If a write wants more bytes than there is free space, only the lowest free-space bytes are stored and the error flag is set. The flag stays set until it is cleared.
- R7: If a read wants more bytes than the level, it returns only the available bytes, zero-fills the other lanes, and sets the error flag.
- R8: Writing 1 to bit 0 of the control register (hostAddr 3) empties the FIFO and sets the level to 0, without changing the error flag. Writing 1 to bit 1 clears the error flag.
- R9: An engine push adds one byte. engFull is 1 when the level equals the depth. A push while full is dropped and sets the error flag.
- R10: engPopData always shows the oldest byte, and an engine pop removes it. A pop while empty leaves the level at 0 and sets the error flag.
- R11: A host data write and an engine pop in the same cycle both take effect. A host data access takes priority over an engine operation on the same side: an engine push during a host data write is dropped, and an engine pop during a host data read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostEn | input | 1 | Host register access strobe |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 2 | 0 data, 1 count, 2 status, 3 control |
| hostWdata | input | 32 | Host write data |
| hostRdData | output | 32 | Registered host read data |
| engPushEn | input | 1 | Engine pushes one byte |
| engPushData | input | 8 | Byte pushed by the engine |
| engPopEn | input | 1 | Engine pops one byte |
| engPopData | output | 8 | Oldest byte in the FIFO |
| engEmpty | output | 1 | Level is zero |
| engFull | output | 1 | Level equals the depth |

## Verification
If a pointer is off by one, bytes come out in the wrong lanes or a stale byte appears. This shows on hostRdData one clock after the read, or on engPopData right after the update edge. If the level counter drifts, the status word is wrong on the very next read. Later, the drift also shows as a missing or a spurious error flag when the FIFO fills or drains. A wrong clamp at the full or empty boundary shows up only at those boundaries. For that reason the checks push the FIFO exactly to its limits and read back the stored bytes there.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;
  localparam int CNT_W = $clog2(LANES + 1);

  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_CTRL   = 2'd3;

  localparam int CTRL_FLUSH_BIT = 0;
  localparam int CTRL_CLRERR_BIT = 1;
  localparam int STATUS_ERR_BIT = 8;

  typedef struct packed {
    logic [CNT_W-1:0] pushCnt;
    logic [CNT_W-1:0] popCnt;
    logic             flush;
    logic [BUS_W-1:0] pushWord;
  } strobe_t;
endpackage

// File: rtl/bfp_datapath.sv
module bfp_datapath
  import bfp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          stb,
  output logic [$clog2(DEPTH+1)-1:0]       level,
  output logic [BUS_W-1:0]                 popWord,
  output logic [7:0]                       engPopData,
  output logic                             engEmpty,
  output logic                             engFull
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!stb.flush && i < int'(stb.pushCnt)) begin
        mem[wrPtr + PTR_W'(i)] <= stb.pushWord[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(stb.pushCnt);
      rdPtr <= rdPtr + PTR_W'(stb.popCnt);
      level <= level + LVL_W'(stb.pushCnt) - LVL_W'(stb.popCnt);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_popLane
    assign popWord[8*g +: 8] = (g < int'(stb.popCnt)) ? mem[rdPtr + PTR_W'(g)] : 8'h00;
  end

  assign engPopData = mem[rdPtr];
  assign engEmpty   = (level == '0);
  assign engFull    = (level == LVL_W'(DEPTH));
endmodule

// File: rtl/bfp_ctrl.sv
module bfp_ctrl
  import bfp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostEn,
  input  logic                       hostWe,
  input  logic [1:0]                 hostAddr,
  input  logic [BUS_W-1:0]           hostWdata,
  output logic [BUS_W-1:0]           hostRdData,
  input  logic                       engPushEn,
  input  logic [7:0]                 engPushData,
  input  logic                       engPopEn,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic [BUS_W-1:0]           popWord,
  output strobe_t                    stb,
  output logic                       errFlag
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] pushWant;
  logic [CNT_W-1:0] popWant;
  logic [LVL_W-1:0] freeBytes;
  logic             hostWr;
  logic             hostRd;
  logic             ctrlWr;
  logic             errSet;
  logic             errClr;
  logic [CNT_W-1:0] cntNew;
  logic             cntOk;
  logic [BUS_W-1:0] statusWord;

  always_comb begin
    hostWr    = hostEn && hostWe && (hostAddr == ADDR_DATA);
    hostRd    = hostEn && !hostWe && (hostAddr == ADDR_DATA);
    ctrlWr    = hostEn && hostWe && (hostAddr == ADDR_CTRL);
    pushWant  = hostWr ? cntReg : (engPushEn ? CNT_W'(1) : '0);
    popWant   = hostRd ? cntReg : (engPopEn ? CNT_W'(1) : '0);
    freeBytes = LVL_W'(DEPTH) - level;
    errSet    = (LVL_W'(pushWant) > freeBytes) || (LVL_W'(popWant) > level);
    errClr    = ctrlWr && hostWdata[CTRL_CLRERR_BIT];

    stb.flush    = ctrlWr && hostWdata[CTRL_FLUSH_BIT];
    stb.pushWord = hostWr ? hostWdata : {{(BUS_W-8){1'b0}}, engPushData};
    stb.pushCnt  = (LVL_W'(pushWant) > freeBytes) ? CNT_W'(freeBytes) : pushWant;
    stb.popCnt   = (LVL_W'(popWant) > level) ? CNT_W'(level) : popWant;
    if (stb.flush) begin
      stb.pushCnt = '0;
      stb.popCnt  = '0;
    end

    cntNew = hostWdata[CNT_W-1:0];
    cntOk  = (cntNew != '0) && (int'(cntNew) <= LANES);

    statusWord = '0;
    statusWord[LVL_W-1:0] = level;
    statusWord[STATUS_ERR_BIT] = errFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg     <= CNT_W'(LANES);
      errFlag    <= 1'b0;
      hostRdData <= '0;
    end else begin
      if (errSet) begin
        errFlag <= 1'b1;
      end else if (errClr) begin
        errFlag <= 1'b0;
      end
      if (hostEn && hostWe && hostAddr == ADDR_COUNT && cntOk) begin
        cntReg <= cntNew;
      end
      if (hostEn && !hostWe) begin
        case (hostAddr)
          ADDR_DATA:   hostRdData <= popWord;
          ADDR_COUNT:  hostRdData <= {{(BUS_W-CNT_W){1'b0}}, cntReg};
          ADDR_STATUS: hostRdData <= statusWord;
          default:     hostRdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/bytefifo_port.sv
module bytefifo_port
  import bfp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostEn,
  input  logic        hostWe,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdData,
  input  logic        engPushEn,
  input  logic [7:0]  engPushData,
  input  logic        engPopEn,
  output logic [7:0]  engPopData,
  output logic        engEmpty,
  output logic        engFull
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  strobe_t          stb;
  logic [LVL_W-1:0] level;
  logic [BUS_W-1:0] popWord;
  logic             errFlag;

  bfp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdData(hostRdData),
    .engPushEn(engPushEn), .engPushData(engPushData), .engPopEn(engPopEn),
    .level(level), .popWord(popWord), .stb(stb), .errFlag(errFlag)
  );

  bfp_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .level(level), .popWord(popWord),
    .engPopData(engPopData), .engEmpty(engEmpty), .engFull(engFull)
  );
endmodule

// File: rtl/bfp_checker.sv
module bfp_checker
  import bfp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       hostEn,
  input logic                       hostWe,
  input logic [1:0]                 hostAddr,
  input logic [31:0]                hostWdata,
  input logic                       engPopEn,
  input logic                       engEmpty,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input strobe_t                    stb,
  input logic                       errFlag
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  logic clrReq;
  logic hostRdData;
  assign clrReq = hostEn && hostWe && hostAddr == ADDR_CTRL && hostWdata[CTRL_CLRERR_BIT];
  assign hostRdData = hostEn && !hostWe && hostAddr == ADDR_DATA;

  // R5: level never exceeds the depth
  a_r5_level_range: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R2, R3: level moves by exactly the granted push and pop counts
  a_r2_level_accounting: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !$past(stb.flush)) |->
      level == $past(level) + LVL_W'($past(stb.pushCnt)) - LVL_W'($past(stb.popCnt)));

  // R8: a flush empties the buffer
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> level == '0);

  // R6: error flag is sticky until cleared
  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrReq) |=> errFlag);

  // R9: nothing is granted into a full buffer
  a_r9_full_no_push: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_W'(DEPTH)) |-> stb.pushCnt == '0);

  // R10: popping an empty buffer raises the error flag
  a_r10_empty_pop_error: assert property (@(posedge clk) disable iff (!rstN)
    (engPopEn && engEmpty && !hostRdData) |=> errFlag);
endmodule

bind bytefifo_port bfp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWe(hostWe),
  .hostAddr(hostAddr), .hostWdata(hostWdata), .engPopEn(engPopEn),
  .engEmpty(engEmpty), .level(level), .stb(stb), .errFlag(errFlag)
);

// File: tb/bytefifo_port_test.sv
module bytefifo_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostEn = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdData;
  logic        engPushEn = 1'b0;
  logic [7:0]  engPushData = '0;
  logic        engPopEn = 1'b0;
  logic [7:0]  engPopData;
  logic        engEmpty;
  logic        engFull;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bytefifo_port uut (
    .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdData(hostRdData),
    .engPushEn(engPushEn), .engPushData(engPushData), .engPopEn(engPopEn),
    .engPopData(engPopData), .engEmpty(engEmpty), .engFull(engFull)
  );

  // count, write word, expected read word
  localparam logic [67:0] VEC [6] = '{
    {4'd1, 32'h12345678, 32'h00000078},
    {4'd2, 32'h12345678, 32'h00005678},
    {4'd3, 32'hDEADBEEF, 32'h00ADBEEF},
    {4'd4, 32'hDEADBEEF, 32'hDEADBEEF},
    {4'd2, 32'hFFFF0000, 32'h00000000},
    {4'd3, 32'h80706050, 32'h00706050}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] addr, input logic [31:0] data);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = addr; hostWdata = data;
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] addr, output logic [31:0] data);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b0; hostAddr = addr;
    @(negedge clk);
    hostEn = 1'b0;
    data = hostRdData;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk);
    engPushEn = 1'b1; engPushData = b;
    @(negedge clk);
    engPushEn = 1'b0;
  endtask

  task automatic engPop(output logic [7:0] b);
    @(negedge clk);
    b = engPopData;
    engPopEn = 1'b1;
    @(negedge clk);
    engPopEn = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 engEmpty", {31'b0, engEmpty}, 32'd1);
    check("R1 engFull", {31'b0, engFull}, 32'd0);
    check("R1 hostRdData", hostRdData, 32'd0);
    rstN = 1'b1;
    hostRead(2'd2, rd); check("R1 status", rd, 32'h0);
    hostRead(2'd1, rd); check("R1 count", rd, 32'd4);

    // Vector table: R2/R3 packing with each count
    foreach (VEC[i]) begin
      hostWrite(2'd1, {28'b0, VEC[i][67:64]});
      hostWrite(2'd0, VEC[i][63:32]);
      hostRead(2'd2, rd); check("R5 level after write", rd, {28'b0, VEC[i][67:64]});
      hostRead(2'd0, rd); check("R3 packed read", rd, VEC[i][31:0]);
      hostRead(2'd2, rd); check("R5 level after read", rd, 32'h0);
    end

    // R4 count register filtering
    hostWrite(2'd1, 32'd3);
    hostWrite(2'd1, 32'd0);
    hostRead(2'd1, rd); check("R4 zero ignored", rd, 32'd3);
    hostWrite(2'd1, 32'd5);
    hostRead(2'd1, rd); check("R4 five ignored", rd, 32'd3);

    // R2 byte order seen by engine (count 3)
    hostWrite(2'd0, 32'hAABBCCDD);
    engPop(b); check("R2 first byte", {24'b0, b}, 32'hDD);
    engPop(b); check("R2 second byte", {24'b0, b}, 32'hCC);
    engPop(b); check("R2 third byte", {24'b0, b}, 32'hBB);
    check("R10 empty after pops", {31'b0, engEmpty}, 32'd1);

    // R3 packing of engine-pushed bytes
    engPush(8'h11); engPush(8'h22); engPush(8'h33); engPush(8'h44);
    hostWrite(2'd1, 32'd2);
    hostRead(2'd0, rd); check("R3 low pair", rd, 32'h00002211);
    hostRead(2'd0, rd); check("R3 high pair", rd, 32'h00004433);

    // R6/R9 fill to full
    hostWrite(2'd3, 32'h3);
    hostWrite(2'd1, 32'd4);
    for (int k = 1; k <= 16; k++) hostWrite(2'd0, {4{8'(k)}});
    hostRead(2'd2, rd); check("R5 full level no error", rd, 32'h40);
    check("R9 engFull", {31'b0, engFull}, 32'd1);
    hostWrite(2'd0, 32'hEEEEEEEE);
    hostRead(2'd2, rd); check("R6 overflow flag", rd, 32'h140);
    engPush(8'h77);
    hostRead(2'd2, rd); check("R9 push while full dropped", rd, 32'h140);
    hostRead(2'd0, rd); check("R3 oldest word", rd, 32'h01010101);
    hostWrite(2'd3, 32'h1);
    hostRead(2'd2, rd); check("R8 flush keeps error", rd, 32'h100);
    check("R8 engEmpty after flush", {31'b0, engEmpty}, 32'd1);
    hostWrite(2'd3, 32'h2);
    hostRead(2'd2, rd); check("R8 error cleared", rd, 32'h0);

    // R6 partial overflow stores low bytes only
    for (int k = 0; k < 15; k++) hostWrite(2'd0, 32'h01020304);
    hostWrite(2'd1, 32'd2);
    hostWrite(2'd0, 32'h0000BBAA);
    hostWrite(2'd1, 32'd4);
    hostWrite(2'd0, 32'h44332211);
    hostRead(2'd2, rd); check("R6 partial overflow", rd, 32'h140);
    for (int k = 0; k < 15; k++) hostRead(2'd0, rd);
    hostWrite(2'd1, 32'd2);
    hostRead(2'd0, rd); check("R6 word before", rd, 32'h0000BBAA);
    hostRead(2'd0, rd); check("R6 low bytes kept", rd, 32'h00002211);
    hostRead(2'd2, rd); check("R6 drained", rd, 32'h100);

    // R7 underflow
    hostWrite(2'd3, 32'h3);
    hostWrite(2'd1, 32'd4);
    engPush(8'h5A);
    hostRead(2'd0, rd); check("R7 short read", rd, 32'h0000005A);
    hostRead(2'd2, rd); check("R7 underflow flag", rd, 32'h100);

    // R10 empty engine pop
    hostWrite(2'd3, 32'h2);
    engPop(b);
    hostRead(2'd2, rd); check("R10 empty pop", rd, 32'h100);
    hostWrite(2'd3, 32'h2);

    // R11 host write with engine pop in one cycle
    engPush(8'hAA);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = 2'd0; hostWdata = 32'h04030201;
    b = engPopData; engPopEn = 1'b1;
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0; engPopEn = 1'b0;
    check("R11 popped byte", {24'b0, b}, 32'hAA);
    hostRead(2'd2, rd); check("R11 level both sides", rd, 32'h4);
    engPop(b); check("R11 byte0", {24'b0, b}, 32'h01);
    engPop(b); engPop(b); engPop(b); check("R11 byte3", {24'b0, b}, 32'h04);

    // R11 engine push dropped during host write
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = 2'd0; hostWdata = 32'h0D0C0B0A;
    engPushEn = 1'b1; engPushData = 8'h99;
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0; engPushEn = 1'b0;
    hostRead(2'd2, rd); check("R11 engine push dropped", rd, 32'h4);
    hostRead(2'd0, rd); check("R11 host word intact", rd, 32'h0D0C0B0A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule